// File: doc/BRIEF.md
# DMA Host Control Register File

This block is a bank of 32-bit memory-mapped registers. A host processor uses it to set up DMA transfers in two directions, launch them, and poll for their completion. The egress channel moves data out of local memory. The ingress channel moves data into local memory. Each channel holds three things the host programs:

- a source address,
- a destination address,
- a byte count.

Addresses on the host side of the link are 64 bits wide, split into low and high words. Local addresses are 32 bits.

One control/status word carries a start bit and a done bit for each channel:

- A start bit reads 1 while its transfer runs and clears itself when the transfer engine reports completion.
- The done bit is set on that same clock edge.
- Setting both start bits in one write launches both channels together.

Each channel also has a read-only cycle counter. It counts only while that channel is busy, so the host can compute throughput after completion.

The downstream engine sees three kinds of signal per channel:

- a one-cycle start pulse,
- the parameter values, held steady for the whole transfer,
- a done input that ends the transfer.

Top module: `dma_host_regs`

## Requirements
- R1: After reset, every register reads 0, both start outputs are low and `reg_rvalid` is low.
- R2: A read request returns `reg_rdata` with `reg_rvalid` high exactly one cycle later. Unmapped offsets read 0. Register offsets are as follows:
  - 0x00: control/status
  - 0x04: egress source
  - 0x08: egress destination low
  - 0x0C: egress destination high
  - 0x10: egress size
  - 0x14: ingress source low
  - 0x18: ingress source high
  - 0x1C: ingress destination
  - 0x20: ingress size
  - 0x24: egress counter
  - 0x28: ingress counter
- R3: Bits [6:0] of every address register are forced to 0 on write, so every address is 128-byte aligned.
- R4: Writing 1 to control bit 0 while the egress channel is idle with a valid size has three effects. Bit 0 reads 1. Egress done (bit 1) is cleared. `eg_start` pulses high for exactly the one cycle after the write, with the programmed source, destination and size on the egress outputs.
- R5: Writing 1 to control bit 2 does the same for the ingress channel. Bit 2 is its start/busy bit, bit 3 is its done bit, and `ig_start` is its pulse.
- R6: Writing 1 to bits 0 and 2 in one access launches both channels, and both start pulses occur in the same cycle.
- R7: A done input seen while its channel is busy clears that channel's start bit and sets its done bit on the same edge. A done input seen while the channel is idle has no effect.
- R8: A size of 0 or above 0x100000 (1 MB) rejects the start. There is no pulse and the control word is unchanged. A size of exactly 0x100000 is accepted.
- R9: Writing 1 to a start bit that is already set is ignored. There is no new pulse and the counter keeps running without restarting.
- R10: Writes to a channel's address and size registers are ignored while that channel is busy.
- R11: A channel's counter is cleared when a start is accepted. It then increments once per cycle while busy, including the completion edge, and holds its value once idle. Writes to counter offsets have no effect.
- R12: Host writes never set a done bit, and writing 0 to a start bit does not stop a running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_re` |
| eg_start | output | 1 | Egress launch pulse |
| eg_src | output | 32 | Egress local source address |
| eg_dst | output | 64 | Egress destination address |
| eg_len | output | 32 | Egress byte count |
| eg_done | input | 1 | Egress completion from the engine |
| ig_start | output | 1 | Ingress launch pulse |
| ig_src | output | 64 | Ingress source address |
| ig_dst | output | 32 | Ingress local destination address |
| ig_len | output | 32 | Ingress byte count |
| ig_done | input | 1 | Ingress completion from the engine |

## Verification
A wrong busy flag appears at the ports in one of three ways:
- a missing or extra start pulse in the cycle after the control write,
- a start bit that reads back wrongly on the next read,
- a counter value that differs from the exact number of busy cycles.

The counter therefore exposes any mistimed completion or a restart of a running transfer, as soon as it is read after completion. Corrupted parameter registers show on the engine outputs during the start pulse. They also show on read-back one cycle after the read request.

// File: rtl/dma_host_regs.sv
module dma_host_regs #(
  parameter int          AW         = 8,
  parameter int          ALIGN_BITS = 7,
  parameter logic [31:0] MAX_LEN    = 32'h0010_0000,
  parameter int          CNT_W      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  input  logic          reg_re,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  output logic          eg_start,
  output logic [31:0]   eg_src,
  output logic [63:0]   eg_dst,
  output logic [31:0]   eg_len,
  input  logic          eg_done,
  output logic          ig_start,
  output logic [63:0]   ig_src,
  output logic [31:0]   ig_dst,
  output logic [31:0]   ig_len,
  input  logic          ig_done
);

  localparam int WI = AW - 2;
  localparam logic [WI-1:0] O_CTRL   = WI'(0);
  localparam logic [WI-1:0] O_EG_SRC = WI'(1);
  localparam logic [WI-1:0] O_EG_DLO = WI'(2);
  localparam logic [WI-1:0] O_EG_DHI = WI'(3);
  localparam logic [WI-1:0] O_EG_LEN = WI'(4);
  localparam logic [WI-1:0] O_IG_SLO = WI'(5);
  localparam logic [WI-1:0] O_IG_SHI = WI'(6);
  localparam logic [WI-1:0] O_IG_DST = WI'(7);
  localparam logic [WI-1:0] O_IG_LEN = WI'(8);
  localparam logic [WI-1:0] O_EG_CNT = WI'(9);
  localparam logic [WI-1:0] O_IG_CNT = WI'(10);
  localparam logic [31:0]   AMASK    = ~((32'd1 << ALIGN_BITS) - 32'd1);

  logic [WI-1:0]    sel;
  logic [31:0]      eg_src_q, eg_dlo_q, eg_dhi_q, eg_len_q;
  logic [31:0]      ig_slo_q, ig_shi_q, ig_dst_q, ig_len_q;
  logic             eg_busy, eg_fin, ig_busy, ig_fin;
  logic             eg_go, ig_go, eg_acc, ig_acc;
  logic [CNT_W-1:0] eg_cnt, ig_cnt;
  logic [31:0]      rmux;

  function automatic logic len_ok(input logic [31:0] l);
    return (l != 32'd0) && (l <= MAX_LEN);
  endfunction

  assign sel    = reg_addr[AW-1:2];
  assign eg_acc = reg_we && sel == O_CTRL && reg_wdata[0] && !eg_busy && len_ok(eg_len_q);
  assign ig_acc = reg_we && sel == O_CTRL && reg_wdata[2] && !ig_busy && len_ok(ig_len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eg_src_q <= '0; eg_dlo_q <= '0; eg_dhi_q <= '0; eg_len_q <= '0;
    end else if (reg_we && !eg_busy) begin
      case (sel)
        O_EG_SRC: eg_src_q <= reg_wdata & AMASK;
        O_EG_DLO: eg_dlo_q <= reg_wdata & AMASK;
        O_EG_DHI: eg_dhi_q <= reg_wdata;
        O_EG_LEN: eg_len_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ig_slo_q <= '0; ig_shi_q <= '0; ig_dst_q <= '0; ig_len_q <= '0;
    end else if (reg_we && !ig_busy) begin
      case (sel)
        O_IG_SLO: ig_slo_q <= reg_wdata & AMASK;
        O_IG_SHI: ig_shi_q <= reg_wdata;
        O_IG_DST: ig_dst_q <= reg_wdata & AMASK;
        O_IG_LEN: ig_len_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eg_busy <= 1'b0; eg_fin <= 1'b0; eg_go <= 1'b0; eg_cnt <= '0;
    end else begin
      eg_go <= eg_acc;
      if (eg_acc) begin
        eg_busy <= 1'b1; eg_fin <= 1'b0; eg_cnt <= '0;
      end else if (eg_busy) begin
        eg_cnt <= eg_cnt + 1'b1;
        if (eg_done) begin
          eg_busy <= 1'b0; eg_fin <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ig_busy <= 1'b0; ig_fin <= 1'b0; ig_go <= 1'b0; ig_cnt <= '0;
    end else begin
      ig_go <= ig_acc;
      if (ig_acc) begin
        ig_busy <= 1'b1; ig_fin <= 1'b0; ig_cnt <= '0;
      end else if (ig_busy) begin
        ig_cnt <= ig_cnt + 1'b1;
        if (ig_done) begin
          ig_busy <= 1'b0; ig_fin <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (sel)
      O_CTRL:   rmux = {28'd0, ig_fin, ig_busy, eg_fin, eg_busy};
      O_EG_SRC: rmux = eg_src_q;
      O_EG_DLO: rmux = eg_dlo_q;
      O_EG_DHI: rmux = eg_dhi_q;
      O_EG_LEN: rmux = eg_len_q;
      O_IG_SLO: rmux = ig_slo_q;
      O_IG_SHI: rmux = ig_shi_q;
      O_IG_DST: rmux = ig_dst_q;
      O_IG_LEN: rmux = ig_len_q;
      O_EG_CNT: rmux = 32'(eg_cnt);
      O_IG_CNT: rmux = 32'(ig_cnt);
      default:  rmux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0; reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_re;
      if (reg_re) reg_rdata <= rmux;
    end
  end

  assign eg_start = eg_go;
  assign eg_src   = eg_src_q;
  assign eg_dst   = {eg_dhi_q, eg_dlo_q};
  assign eg_len   = eg_len_q;
  assign ig_start = ig_go;
  assign ig_src   = {ig_shi_q, ig_slo_q};
  assign ig_dst   = ig_dst_q;
  assign ig_len   = ig_len_q;

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid == $past(reg_re));
  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eg_src[6:0] == 0 && eg_dst[6:0] == 0 && ig_src[6:0] == 0 && ig_dst[6:0] == 0);
  assert_eg_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eg_start |=> !eg_start);
  assert_ig_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ig_start |-> ig_busy && !ig_fin);
  assert_eg_fin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eg_busy) |-> $past(eg_done) && eg_fin);
  assert_ig_fin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ig_fin) |-> $fell(ig_busy));
  assert_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_start |-> len_ok(eg_len)) and (ig_start |-> len_ok(ig_len)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eg_busy) && eg_busy |-> $stable(eg_len) && $stable(eg_dst) && $stable(eg_src));
  assert_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ig_busy) && !ig_busy |-> $stable(ig_cnt));

endmodule

// File: tb/test_dma_host_regs.sv
module test_dma_host_regs;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic        reg_we = 0, reg_re = 0, eg_done = 0, ig_done = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        reg_rvalid, eg_start, ig_start;
  logic [31:0] eg_src, eg_len, ig_dst, ig_len;
  logic [63:0] eg_dst, ig_src;
  int total = 0, bad = 0;
  logic [31:0] r;

  always #10 clk = ~clk;

  dma_host_regs i_dma_host_regs (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_re = 1;
    @(posedge clk); @(negedge clk);
    reg_re = 0;
    check("R2 rvalid", reg_rvalid, 1);
    d = reg_rdata;
  endtask

  task automatic pulse_done(bit eg, bit ig);
    eg_done = eg; ig_done = ig;
    @(negedge clk);
    eg_done = 0; ig_done = 0;
  endtask

  task automatic t_reset();
    check("R1 eg_start", eg_start, 0);
    check("R1 ig_start", ig_start, 0);
    check("R1 rvalid", reg_rvalid, 0);
    for (int a = 0; a <= 8'h28; a += 4) begin
      rd(a[7:0], r); check("R1 reset value", r, 0);
    end
    rd(8'h3c, r); check("R2 unmapped", r, 0);
    @(negedge clk);
    check("R2 rvalid drops", reg_rvalid, 0);
  endtask

  task automatic t_align();
    wr(8'h04, 32'h1234_56FF); wr(8'h08, 32'hABCD_EF7F);
    wr(8'h0C, 32'h0000_00FF); wr(8'h10, 32'd4096);
    wr(8'h14, 32'h8000_00C1); wr(8'h18, 32'h0000_0001);
    wr(8'h1C, 32'h0000_1FFF); wr(8'h20, 32'd9600);
    rd(8'h04, r); check("R3 eg src", r, 32'h1234_5680);
    rd(8'h08, r); check("R3 eg dst lo", r, 32'hABCD_EF00);
    rd(8'h0C, r); check("R3 eg dst hi", r, 32'h0000_00FF);
    rd(8'h14, r); check("R3 ig src lo", r, 32'h8000_0080);
    rd(8'h1C, r); check("R3 ig dst", r, 32'h0000_1F80);
  endtask

  task automatic t_egress();
    wr(8'h00, 32'h1);
    check("R4 eg_start", eg_start, 1);
    check("R4 eg_src", eg_src, 32'h1234_5680);
    check("R4 eg_dst", eg_dst, 64'h0000_00FF_ABCD_EF00);
    check("R4 eg_len", eg_len, 32'd4096);
    check("R4 ig quiet", ig_start, 0);
    rd(8'h00, r);
    check("R4 eg_start one cycle", eg_start, 0);
    check("R4 ctrl busy", r, 32'h1);
    wr(8'h10, 32'd128);
    check("R10 eg_len held", eg_len, 32'd4096);
    wr(8'h00, 32'h0);
    rd(8'h00, r); check("R12 write 0 keeps busy", r, 32'h1);
    pulse_done(1, 0);
    rd(8'h00, r); check("R7 eg done", r, 32'h2);
    rd(8'h10, r); check("R10 eg_len unchanged", r, 32'd4096);
  endtask

  task automatic t_ingress();
    wr(8'h00, 32'h4);
    check("R5 ig_start", ig_start, 1);
    check("R5 ig_src", ig_src, 64'h0000_0001_8000_0080);
    check("R5 ig_dst", ig_dst, 32'h0000_1F80);
    check("R5 ig_len", ig_len, 32'd9600);
    check("R5 eg quiet", eg_start, 0);
    rd(8'h00, r); check("R5 ctrl", r, 32'h6);
    pulse_done(0, 1);
    rd(8'h00, r); check("R7 ig done", r, 32'hA);
    pulse_done(1, 1);
    rd(8'h00, r); check("R7 idle done ignored", r, 32'hA);
    wr(8'h00, 32'hA);
    rd(8'h00, r); check("R12 cannot set done", r, 32'hA);
  endtask

  task automatic t_duplex();
    wr(8'h00, 32'h5);
    check("R6 eg_start", eg_start, 1);
    check("R6 ig_start", ig_start, 1);
    rd(8'h00, r); check("R6 both busy, dones cleared", r, 32'h5);
    pulse_done(1, 1);
    rd(8'h00, r); check("R6 both done", r, 32'hA);
  endtask

  task automatic t_size();
    wr(8'h10, 32'd0); wr(8'h00, 32'h1);
    check("R8 zero size no pulse", eg_start, 0);
    rd(8'h00, r); check("R8 zero size ctrl", r, 32'hA);
    wr(8'h20, 32'h0010_0001); wr(8'h00, 32'h4);
    check("R8 oversize no pulse", ig_start, 0);
    rd(8'h00, r); check("R8 oversize ctrl", r, 32'hA);
    wr(8'h20, 32'h0010_0000); wr(8'h00, 32'h4);
    check("R8 1MB accepted", ig_start, 1);
    pulse_done(0, 1);
    wr(8'h10, 32'd1); wr(8'h00, 32'h1);
    check("R8 size 1 accepted", eg_start, 1);
    pulse_done(1, 0);
  endtask

  task automatic t_counter();
    wr(8'h10, 32'd256); wr(8'h00, 32'h1);
    repeat (6) @(negedge clk);
    pulse_done(1, 0);
    rd(8'h24, r); check("R11 eg count", r, 7);
    repeat (3) @(negedge clk);
    rd(8'h24, r); check("R11 eg count holds", r, 7);
    wr(8'h24, 32'h55); wr(8'h28, 32'h55);
    rd(8'h24, r); check("R11 counter read-only", r, 7);
    rd(8'h28, r); check("R11 ig counter untouched", r, 1);
    wr(8'h00, 32'h4);
    repeat (2) @(negedge clk);
    wr(8'h00, 32'h4);
    check("R9 no repulse", ig_start, 0);
    pulse_done(0, 1);
    rd(8'h28, r); check("R9 count not restarted", r, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_align(); t_egress(); t_ingress();
    t_duplex(); t_size(); t_counter();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule